// File: doc/BRIEF.md
# Bus-Width Matching Port Adapter

This block sits between a 36-bit queue word and an external data bus whose width can change while the system runs. The bus runs as a full 36-bit long word, an 18-bit word, or a 9-bit byte. The 36-bit word is treated as four 9-bit lanes, and each lane keeps its parity bit in its top position. On writes the adapter gathers one, two or four external transfers into a full word. It then hands that word to the queue with a one-cycle completion strobe. On reads it splits the queue's head word into one, two or four transfers. It raises a request strobe toward the queue when the last piece of the word leaves.

The width and the lane order are chosen with a 2-bit size code and an endian select. Both are captured on one rising clock edge and used from the next rising edge onward. The size code with both bits high is not a queue width. It sends the full 36-bit bus to a mailbox register path instead. The mailbox register lives outside the block; in this mode write transfers strobe it with the bus data and read transfers return its contents. Narrow transfers always use the low lanes of the external bus.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `word_done` low and `word_out` zero. The active configuration returns to long word, little-endian, with no partial word pending.
- R2: `size_sel` and `big_end` are captured at one rising edge and take effect at the following rising edge. A transfer taken at the capture edge still uses the old configuration.
- R3: Long-word mode uses size code 00. Each write transfer raises `word_done` in the next cycle, with `word_out` equal to the full `wr_bus`. Each read transfer shows `word_in` on `rd_bus` and raises `word_req` in the same cycle.
- R4: Word mode uses size code 01. Two write transfers carry data on `wr_bus[17:0]`. With `big_end` high, the first transfer fills `word_out[35:18]`; with it low, the first transfer fills `word_out[17:0]`.
- R5: Byte mode uses size code 10. Four write transfers carry data on `wr_bus[8:0]`. With `big_end` high, the transfers fill lanes 3, 2, 1, 0 in that order, where lane n is bits [9n+8:9n]. With `big_end` low, they fill lanes 0, 1, 2, 3.
- R6: `word_done` pulses only in the cycle after the transfer that completes a word. Earlier transfers of a narrow word leave it low.
- R7: A narrow read presents the head word's lane groups in the same order as writes, on the low lanes of `rd_bus`. `word_req` is high only with the read transfer that carries the last group.
- R8: During a narrow read, the `rd_bus` lanes above the active width are zero.
- R9: Size code 11 selects the mailbox. A write transfer raises `mbox_wr` and never `word_done`. `rd_bus` equals `mbox_rdata`, and a read transfer raises `mbox_rd` and never `word_req`.
- R10: When a new size or endian value is applied, any partially packed write word is dropped and the read position restarts at the first group. A transfer at the applying edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| size_sel | input | 2 | Bus size code: 00 long word, 01 word, 10 byte, 11 mailbox |
| big_end | input | 1 | 1 selects big-endian group order for narrow sizes |
| wr_xfer | input | 1 | One external write transfer this cycle |
| wr_bus | input | 36 | External write data; narrow sizes use the low bits |
| rd_xfer | input | 1 | One external read transfer this cycle |
| rd_bus | output | 36 | External read data; unused high lanes are zero |
| word_out | output | 36 | Assembled word toward the queue |
| word_done | output | 1 | One-cycle strobe: `word_out` holds a complete word |
| word_in | input | 36 | Head word of the queue, valid while it is being read |
| word_req | output | 1 | Head word fully read; the queue advances |
| mbox_wr | output | 1 | Mailbox write strobe; the data is `wr_bus` |
| mbox_rd | output | 1 | Mailbox read strobe |
| mbox_rdata | input | 36 | Mailbox register contents |

## Verification
The assertions take for granted that `word_in` holds the queue's head word for as long as it is being read, and that `wr_bus` is meaningful only while `wr_xfer` is high. The long-word commit property also assumes that no transfer arrives on a cycle where a new configuration is being applied. The stimulus meets these conditions by design. It changes the configuration only through a task that waits out both the capture edge and the apply edge before the next transfer. The one deliberate exception is the capture-edge check. It drives a transfer together with the new size, so the transfer lands on the capture edge and never on the apply edge. Every input is driven at the falling edge, and `word_in` is held steady across a whole read sequence.

// File: rtl/bwa_pkg.sv
// Package: shared size-code type and helpers for the bus-width adapter.
// Assumes the internal word is a power-of-two number of lanes, at least four.
package bwa_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_MBOX = 2'b11
    } size_e;

    // log2 of the number of transfers per word for a size code
    function automatic logic [1:0] xfer_shift(size_e sz);
        case (sz)
            SZ_WORD: xfer_shift = 2'd1;
            SZ_BYTE: xfer_shift = 2'd2;
            default: xfer_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bwa_size_ctl.sv
// Size/endian control: a two-stage capture-then-apply pipeline.
// Assumes size_sel and big_end are synchronous to clk.
module bwa_size_ctl
    import bwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] size_sel,
    input  logic       big_end,
    output size_e      act_size,
    output logic       act_big,
    output logic       cfg_change
);

    size_e cap_size;
    logic  cap_big;

    // Capture the inputs on one edge and apply them on the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_size <= SZ_LONG;
            cap_big  <= 1'b0;
            act_size <= SZ_LONG;
            act_big  <= 1'b0;
        end else begin
            cap_size <= size_e'(size_sel);
            cap_big  <= big_end;
            act_size <= cap_size;
            act_big  <= cap_big;
        end
    end

    // Flag that the coming edge installs a different configuration
    always_comb begin
        cfg_change = (cap_size != act_size) || (cap_big != act_big);
    end

endmodule

// File: rtl/bwa_packer.sv
// Write packer: gathers 1, 2 or 4 narrow transfers into one full word.
// Assumes narrow data arrives on the low lanes of wr_bus. A partial word
// is dropped whenever a new configuration is applied.
module bwa_packer
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  size_e                    act_size,
    input  logic                     act_big,
    input  logic                     cfg_change,
    input  logic                     wr_xfer,
    input  logic [LANE_W*LANES-1:0]  wr_bus,
    output logic [LANE_W*LANES-1:0]  word_out,
    output logic                     word_done
);

    localparam int WORD_W = LANE_W * LANES;
    localparam int LOG_L  = $clog2(LANES);
    localparam int CNT_W  = LOG_L;

    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  grp_sel;
    logic [1:0]        shift;
    logic              mbox;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;

    // Decode the active size into a transfer count and the target group
    always_comb begin
        shift    = xfer_shift(act_size);
        mbox     = (act_size == SZ_MBOX);
        last_idx = CNT_W'((1 << shift) - 1);
        grp_sel  = act_big ? (last_idx - idx) : idx;
    end

    // Merge the current transfer into the lanes of the selected group
    always_comb begin
        merged = acc;
        for (int l = 0; l < LANES; l++) begin
            logic [CNT_W-1:0] grp;
            logic [CNT_W-1:0] slot;
            grp  = CNT_W'(l >> (LOG_L - int'(shift)));
            slot = CNT_W'(l) & CNT_W'((LANES >> shift) - 1);
            if (grp == grp_sel) begin
                merged[l*LANE_W +: LANE_W] = wr_bus[int'(slot)*LANE_W +: LANE_W];
            end
        end
    end

    // Advance the packing position and commit a full word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            acc       <= '0;
            word_out  <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (cfg_change) begin
                idx <= '0;
                acc <= '0;
            end else if (wr_xfer && !mbox) begin
                if (idx == last_idx) begin
                    word_out  <= merged;
                    word_done <= 1'b1;
                    idx       <= '0;
                    acc       <= '0;
                end else begin
                    acc <= merged;
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bwa_unpacker.sv
// Read unpacker: presents the head word as 1, 2 or 4 narrow transfers.
// Assumes word_in is steady while a word is being read out. The read
// position restarts whenever a new configuration is applied.
module bwa_unpacker
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  size_e                    act_size,
    input  logic                     act_big,
    input  logic                     cfg_change,
    input  logic                     rd_xfer,
    input  logic [LANE_W*LANES-1:0]  word_in,
    input  logic [LANE_W*LANES-1:0]  mbox_rdata,
    output logic [LANE_W*LANES-1:0]  rd_bus,
    output logic                     word_req,
    output logic                     mbox_rd
);

    localparam int LOG_L = $clog2(LANES);
    localparam int CNT_W = LOG_L;

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] grp_sel;
    logic [1:0]       shift;
    logic             mbox;

    // Decode the active size into a transfer count and the source group
    always_comb begin
        shift    = xfer_shift(act_size);
        mbox     = (act_size == SZ_MBOX);
        last_idx = CNT_W'((1 << shift) - 1);
        grp_sel  = act_big ? (last_idx - idx) : idx;
    end

    // Route the selected group to the low lanes and zero the rest
    always_comb begin
        rd_bus = '0;
        for (int l = 0; l < LANES; l++) begin
            logic [CNT_W-1:0] src;
            src = CNT_W'((int'(grp_sel) << (LOG_L - int'(shift))) + l);
            if (mbox) begin
                rd_bus[l*LANE_W +: LANE_W] = mbox_rdata[l*LANE_W +: LANE_W];
            end else if (l < (LANES >> shift)) begin
                rd_bus[l*LANE_W +: LANE_W] = word_in[int'(src)*LANE_W +: LANE_W];
            end
        end
    end

    // Strobe the queue on the last group, or the mailbox in mailbox mode
    always_comb begin
        word_req = rd_xfer && !mbox && !cfg_change && (idx == last_idx);
        mbox_rd  = rd_xfer && mbox;
    end

    // Advance the read position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (cfg_change) begin
            idx <= '0;
        end else if (rd_xfer && !mbox) begin
            idx <= (idx == last_idx) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/bus_width_adapter.sv
// Top of the bus-width adapter: size control, write packer, read unpacker
// and mailbox diversion. Assumes one clock domain and synchronous inputs.
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               size_sel,
    input  logic                     big_end,
    input  logic                     wr_xfer,
    input  logic [LANE_W*LANES-1:0]  wr_bus,
    input  logic                     rd_xfer,
    output logic [LANE_W*LANES-1:0]  rd_bus,
    output logic [LANE_W*LANES-1:0]  word_out,
    output logic                     word_done,
    input  logic [LANE_W*LANES-1:0]  word_in,
    output logic                     word_req,
    output logic                     mbox_wr,
    output logic                     mbox_rd,
    input  logic [LANE_W*LANES-1:0]  mbox_rdata
);

    size_e act_size;
    logic  act_big;
    logic  cfg_change;

    bwa_size_ctl u_size (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_sel   (size_sel),
        .big_end    (big_end),
        .act_size   (act_size),
        .act_big    (act_big),
        .cfg_change (cfg_change)
    );

    bwa_packer #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_size   (act_size),
        .act_big    (act_big),
        .cfg_change (cfg_change),
        .wr_xfer    (wr_xfer),
        .wr_bus     (wr_bus),
        .word_out   (word_out),
        .word_done  (word_done)
    );

    bwa_unpacker #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_size   (act_size),
        .act_big    (act_big),
        .cfg_change (cfg_change),
        .rd_xfer    (rd_xfer),
        .word_in    (word_in),
        .mbox_rdata (mbox_rdata),
        .rd_bus     (rd_bus),
        .word_req   (word_req),
        .mbox_rd    (mbox_rd)
    );

    // Divert write transfers to the mailbox under the reserved size code
    always_comb begin
        mbox_wr = wr_xfer && (act_size == SZ_MBOX);
    end

endmodule

// File: rtl/bwa_checker.sv
// Property checker for bus_width_adapter, attached with bind.
// Assumes no transfer coincides with a configuration being applied.
module bwa_checker
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input size_e                   act_size,
    input logic                    cfg_change,
    input logic                    wr_xfer,
    input logic                    rd_xfer,
    input logic [LANE_W*LANES-1:0] wr_bus,
    input logic [LANE_W*LANES-1:0] rd_bus,
    input logic [LANE_W*LANES-1:0] word_out,
    input logic                    word_done,
    input logic                    word_req,
    input logic                    mbox_wr
);

    localparam int WORD_W = LANE_W * LANES;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!word_done && word_out == '0));

    // R3
    long_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_size == SZ_LONG && wr_xfer && !cfg_change)
        |=> (word_done && word_out == $past(wr_bus)));

    // R6
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(wr_xfer));

    // R7
    req_with_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_req |-> rd_xfer);

    // R8
    byte_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_size == SZ_BYTE) |-> (rd_bus[WORD_W-1:LANE_W] == '0));

    // R9
    mbox_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_wr |=> !word_done);

endmodule

bind bus_width_adapter bwa_checker #(.LANE_W(LANE_W), .LANES(LANES)) i_bwa_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_size   (act_size),
    .cfg_change (cfg_change),
    .wr_xfer    (wr_xfer),
    .rd_xfer    (rd_xfer),
    .wr_bus     (wr_bus),
    .rd_bus     (rd_bus),
    .word_out   (word_out),
    .word_done  (word_done),
    .word_req   (word_req),
    .mbox_wr    (mbox_wr)
);

// File: tb/test_bus_width_adapter.sv
// Directed bench for bus_width_adapter: one task per scenario.
module test_bus_width_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  size_sel = 2'b00;
    logic        big_end = 1'b0;
    logic        wr_xfer = 1'b0;
    logic [35:0] wr_bus = '0;
    logic        rd_xfer = 1'b0;
    logic [35:0] rd_bus;
    logic [35:0] word_out;
    logic        word_done;
    logic [35:0] word_in = '0;
    logic        word_req;
    logic        mbox_wr;
    logic        mbox_rd;
    logic [35:0] mbox_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    bus_width_adapter i_bus_width_adapter (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
        .wr_xfer(wr_xfer), .wr_bus(wr_bus), .rd_xfer(rd_xfer), .rd_bus(rd_bus),
        .word_out(word_out), .word_done(word_done), .word_in(word_in),
        .word_req(word_req), .mbox_wr(mbox_wr), .mbox_rd(mbox_rd),
        .mbox_rdata(mbox_rdata)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drive a new size/endian and wait through capture and apply edges
    task automatic set_cfg(input logic [1:0] sz, input logic be);
        @(negedge clk);
        size_sel = sz;
        big_end  = be;
        @(negedge clk);
        @(negedge clk);
    endtask

    // One write transfer; returns at the falling edge after it was taken
    task automatic wr_one(input logic [35:0] d);
        @(negedge clk);
        wr_xfer = 1'b1;
        wr_bus  = d;
        @(negedge clk);
        wr_xfer = 1'b0;
        wr_bus  = '0;
    endtask

    // One read transfer, checking the bus and the queue strobe before the edge
    task automatic rd_one(input string req, input logic [35:0] exp_bus, input logic exp_req);
        @(negedge clk);
        rd_xfer = 1'b1;
        #1;
        chk(req, rd_bus, exp_bus);
        chk(req, {35'd0, word_req}, {35'd0, exp_req});
        @(negedge clk);
        rd_xfer = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 done", {35'd0, word_done}, 36'd0);
        chk("R1 word", word_out, 36'd0);
        word_in = 36'h9_1234_5678;
        #1;
        chk("R1 long default", rd_bus, 36'h9_1234_5678);
    endtask

    task automatic t_long();
        wr_one(36'hA_BCDE_F012);
        chk("R3 done", {35'd0, word_done}, 36'd1);
        chk("R3 word", word_out, 36'hA_BCDE_F012);
        word_in = 36'h5_5AA5_0FF0;
        rd_one("R3 read", 36'h5_5AA5_0FF0, 1'b1);
    endtask

    task automatic t_word_write();
        set_cfg(2'b01, 1'b1);
        wr_one(36'h0_0003_1111);
        chk("R6 word partial", {35'd0, word_done}, 36'd0);
        wr_one(36'h0_0002_2222);
        chk("R4 big done", {35'd0, word_done}, 36'd1);
        chk("R4 big word", word_out, {18'h3_1111, 18'h2_2222});
        set_cfg(2'b01, 1'b0);
        wr_one(36'h0_0001_AAAA);
        wr_one(36'h0_0000_5555);
        chk("R4 little word", word_out, {18'h0_5555, 18'h1_AAAA});
    endtask

    task automatic t_byte_write();
        set_cfg(2'b10, 1'b1);
        wr_one(36'h0_0000_0111);
        wr_one(36'h0_0000_0022);
        wr_one(36'h0_0000_0133);
        chk("R6 byte partial", {35'd0, word_done}, 36'd0);
        wr_one(36'h0_0000_0044);
        chk("R5 big word", word_out, {9'h111, 9'h022, 9'h133, 9'h044});
        set_cfg(2'b10, 1'b0);
        wr_one(36'h0_0000_01A1);
        wr_one(36'h0_0000_00B2);
        wr_one(36'h0_0000_01C3);
        wr_one(36'h0_0000_00D4);
        chk("R5 little word", word_out, {9'h0D4, 9'h1C3, 9'h0B2, 9'h1A1});
    endtask

    task automatic t_reads();
        logic [35:0] w;
        w = {9'h1F1, 9'h0E2, 9'h1D3, 9'h0C4};
        word_in = w;
        set_cfg(2'b01, 1'b1);
        rd_one("R7 word big first", {18'd0, w[35:18]}, 1'b0);
        rd_one("R7 word big last", {18'd0, w[17:0]}, 1'b1);
        set_cfg(2'b10, 1'b0);
        rd_one("R8 byte lane0", {27'd0, w[8:0]}, 1'b0);
        rd_one("R8 byte lane1", {27'd0, w[17:9]}, 1'b0);
        rd_one("R7 byte lane2", {27'd0, w[26:18]}, 1'b0);
        rd_one("R7 byte lane3", {27'd0, w[35:27]}, 1'b1);
    endtask

    task automatic t_mbox();
        set_cfg(2'b11, 1'b0);
        mbox_rdata = 36'hC_0FFE_E123;
        @(negedge clk);
        wr_xfer = 1'b1;
        wr_bus  = 36'h1_1111_1111;
        #1;
        chk("R9 mbox_wr", {35'd0, mbox_wr}, 36'd1);
        @(negedge clk);
        wr_xfer = 1'b0;
        chk("R9 no commit", {35'd0, word_done}, 36'd0);
        rd_xfer = 1'b1;
        #1;
        chk("R9 rd_bus", rd_bus, 36'hC_0FFE_E123);
        chk("R9 mbox_rd", {35'd0, mbox_rd}, 36'd1);
        chk("R9 no req", {35'd0, word_req}, 36'd0);
        @(negedge clk);
        rd_xfer = 1'b0;
    endtask

    task automatic t_pipeline();
        set_cfg(2'b00, 1'b0);
        @(negedge clk);
        size_sel = 2'b10;
        wr_xfer  = 1'b1;
        wr_bus   = 36'h7_7654_3210;
        @(negedge clk);
        wr_xfer = 1'b0;
        chk("R2 capture edge old size", word_out, 36'h7_7654_3210);
        @(negedge clk);
        wr_one(36'h0_0000_0055);
        chk("R2 new size applied", {35'd0, word_done}, 36'd0);
    endtask

    task automatic t_discard();
        logic [35:0] w;
        set_cfg(2'b10, 1'b1);
        wr_one(36'h0_0000_0101);
        wr_one(36'h0_0000_0102);
        set_cfg(2'b01, 1'b1);
        wr_one(36'h0_0002_BBBB);
        chk("R10 first after switch", {35'd0, word_done}, 36'd0);
        wr_one(36'h0_0001_CCCC);
        chk("R10 word after discard", word_out, {18'h2_BBBB, 18'h1_CCCC});
        w = 36'hF_0123_4567;
        word_in = w;
        rd_one("R10 read partial", {18'd0, w[35:18]}, 1'b0);
        set_cfg(2'b10, 1'b1);
        rd_one("R10 read restarts", {27'd0, w[35:27]}, 1'b0);
    endtask

    initial begin
        t_reset();
        t_long();
        t_word_write();
        t_byte_write();
        t_reads();
        t_mbox();
        t_pipeline();
        t_discard();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule